// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Selectable Reset Kind

This block is a down-counting watchdog. Software loads a reload value, enables counting and must write a service strobe before the count runs out. The first expiry is only a warning. It sets a sticky timeout flag and restarts the count. If the count runs out again before any service, the block can issue a reset request, provided that reset generation has been enabled.

A separate 2-bit reset-kind input selects the kind of reset. The request is either a full power-on reset or a lighter system reset. Two of the four codes fall back to the default, which is the full power-on reset. Each request is a single-cycle pulse on one of two outputs. The reset sequencing that follows the pulse is left to the surrounding logic.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the timeout flag and both request outputs are 0, and counting and reset generation are both off.
- R2: Writes use `reg_wr` and `reg_addr`. Address 0 stores the reload value. Address 1 is control: bit 0 enables counting and bit 1 enables reset generation. A write to address 2 is a service. With reload value L, the first expiry comes on the (L+1)-th enabled cycle after counting starts. It sets the flag, visible after that edge, and reloads L.
- R3: The first expiry never produces a reset request.
- R4: While reset generation is off, expiries only set the flag and no request is produced.
- R5: Reset-kind code 3 turns a second unserviced expiry into a one-cycle pulse on `por_req`.
- R6: Reset-kind code 2 turns a second unserviced expiry into a one-cycle pulse on `sysrst_req`.
- R7: Reset-kind codes 0 and 1 behave as the default and pulse `por_req`.
- R8: Only one request pulse is issued per unserviced run, and `por_req` and `sysrst_req` are never high together. Further expiries repeat no pulse until a service.
- R9: A service clears the flag and reloads the counter from the stored reload value. After a service the next expiry counts as a first expiry again.
- R10: While counting is disabled, the count holds its value and no expiry occurs.
- R11: Writing a new reload value does not change the running count. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 reload, 1 control, 2 service) |
| reg_wdata | input | CW | Write data |
| rst_kind | input | 2 | Reset-kind select (3 POR, 2 system, 0/1 default POR) |
| timeout_flag | output | 1 | Sticky flag set on first expiry |
| por_req | output | 1 | One-cycle full power-on reset request |
| sysrst_req | output | 1 | One-cycle system reset request |

## Verification
The main check is a sweep over every reload value from 0 to 5, all four reset-kind codes and both settings of the reset-enable bit. In each case the bench predicts from L alone the cycle of the first expiry, the cycle of the second expiry and the cycle of a third expiry. The reload values separate off-by-one errors in the expiry period, including the zero-reload case. The kind codes separate the decoding and the default fallback. The enable bit shows whether the request is gated. Directed runs add four more cases:
- a service between the two expiries,
- a pause of counting in the middle of a period,
- a reload write in the middle of a period, whose effect is timed against the old and the new value,
- the third expiry, which shows whether pulses repeat.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_RELOAD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CONTROL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SERVICE = 2'd2;

  localparam int CTRL_CNT_EN_BIT = 0;
  localparam int CTRL_RST_EN_BIT = 1;

  typedef enum logic [1:0] {
    KIND_DEFAULT_A = 2'd0,
    KIND_DEFAULT_B = 2'd1,
    KIND_SYSTEM    = 2'd2,
    KIND_POWER_ON  = 2'd3
  } rst_kind_e;

  function automatic logic kind_is_system(input logic [1:0] k);
    return (k == KIND_SYSTEM);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CW = 16,
  parameter logic [CW-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     reload_val,
  output logic              cnt_en,
  output logic              rst_en,
  output logic              svc
);
  logic reload_we, ctrl_we;
  logic [CW-1:0] reload_q;
  logic cnt_en_q, rst_en_q;

  always_comb begin
    reload_we = wr && (addr == ADDR_RELOAD);
    ctrl_we   = wr && (addr == ADDR_CONTROL);
    svc       = wr && (addr == ADDR_SERVICE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_INIT;
    end else if (reload_we) begin
      reload_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en_q <= 1'b0;
      rst_en_q <= 1'b0;
    end else if (ctrl_we) begin
      cnt_en_q <= wdata[CTRL_CNT_EN_BIT];
      rst_en_q <= wdata[CTRL_RST_EN_BIT];
    end
  end

  assign reload_val = reload_q;
  assign cnt_en     = cnt_en_q;
  assign rst_en     = rst_en_q;

  a_r2_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (cnt_en_q == $past(wdata[CTRL_CNT_EN_BIT])));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 16,
  parameter logic [CW-1:0] RELOAD_INIT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          svc,
  input  logic [CW-1:0] reload_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_we;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    cnt_we = 1'b0;
    if (svc) begin
      cnt_d  = reload_val;
      cnt_we = 1'b1;
    end else if (cnt_en) begin
      cnt_we = 1'b1;
      if (cnt_q == '0) begin
        expire = 1'b1;
        cnt_d  = reload_val;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD_INIT;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !svc) |=> $stable(cnt_q));
  a_r10_no_expire_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> !expire);
  a_r9_service_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (cnt_q == $past(reload_val)));
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       svc,
  input  logic       rst_en,
  input  logic [1:0] rst_kind,
  output logic       flag,
  output logic       por_req,
  output logic       sys_req
);
  logic flag_q, flag_d;
  logic fired_q, fired_d;
  logic por_q, por_d, sys_q, sys_d;
  logic second;

  always_comb begin
    flag_d  = flag_q;
    fired_d = fired_q;
    por_d   = 1'b0;
    sys_d   = 1'b0;
    second  = 1'b0;
    if (svc) begin
      flag_d  = 1'b0;
      fired_d = 1'b0;
    end else if (expire) begin
      if (!flag_q) begin
        flag_d = 1'b1;
      end else begin
        second = 1'b1;
        if (rst_en && !fired_q) begin
          fired_d = 1'b1;
          sys_d   = kind_is_system(rst_kind);
          por_d   = !kind_is_system(rst_kind);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      fired_q <= 1'b0;
      por_q   <= 1'b0;
      sys_q   <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      fired_q <= fired_d;
      por_q   <= por_d;
      sys_q   <= sys_d;
    end
  end

  assign flag    = flag_q;
  assign por_req = por_q;
  assign sys_req = sys_q;

  a_r3_first_expiry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !flag_q) |=> (!por_q && !sys_q));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({por_q, sys_q}));
  a_r8_single_por: assert property (@(posedge clk) disable iff (!rst_n)
    por_q |=> !por_q);
  a_r8_single_sys: assert property (@(posedge clk) disable iff (!rst_n)
    sys_q |=> !sys_q);
  a_r6_system_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (second && rst_en && !fired_q && rst_kind == KIND_SYSTEM) |=> sys_q);
  a_r5_r7_por_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (second && rst_en && !fired_q && rst_kind != KIND_SYSTEM) |=> por_q);
  a_r9_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> !flag_q);
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !svc) |=> flag_q);
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int CW = 16,
  parameter logic [CW-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  input  logic [1:0]        rst_kind,
  output logic              timeout_flag,
  output logic              por_req,
  output logic              sysrst_req
);
  logic [1:0]    rst_sync_q;
  logic          srst_n;
  logic [CW-1:0] reload_val;
  logic          cnt_en, rst_en, svc, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign srst_n = rst_sync_q[1];

  wdog_regs #(.CW(CW), .RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .reload_val(reload_val), .cnt_en(cnt_en),
    .rst_en(rst_en), .svc(svc)
  );

  wdog_counter #(.CW(CW), .RELOAD_INIT(RELOAD_INIT)) u_counter (
    .clk(clk), .rst_n(srst_n), .cnt_en(cnt_en), .svc(svc),
    .reload_val(reload_val), .expire(expire)
  );

  wdog_stage u_stage (
    .clk(clk), .rst_n(srst_n), .expire(expire), .svc(svc),
    .rst_en(rst_en), .rst_kind(rst_kind), .flag(timeout_flag),
    .por_req(por_req), .sys_req(sysrst_req)
  );

  a_r4_gate_requests: assert property (@(posedge clk) disable iff (!srst_n)
    !rst_en |=> (!por_req && !sysrst_req));
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !srst_n |-> (!timeout_flag && !por_req && !sysrst_req));
endmodule

// File: tb/wdog_twostage_bench.sv
`timescale 1ns/1ps
module wdog_twostage_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [1:0]    reg_addr;
  logic [CW-1:0] reg_wdata;
  logic [1:0]    rst_kind;
  logic          timeout_flag, por_req, sysrst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_twostage #(.CW(CW)) u_wdog_twostage (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rst_kind(rst_kind), .timeout_flag(timeout_flag),
    .por_req(por_req), .sysrst_req(sysrst_req)
  );

  function automatic int outs();
    return {29'd0, timeout_flag, por_req, sysrst_req};
  endfunction

  task automatic check(input string tag, input int exp);
    int act;
    act = outs();
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual={flag,por,sys}=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; the next posedge is the write edge.
  task automatic wr_reg(input logic [1:0] a, input logic [CW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic arm(input int load, input bit ren);
    wr_reg(2'd1, '0);
    wr_reg(2'd0, CW'(load));
    wr_reg(2'd2, '0);
    check("R9 service clears flag", 0);
    wr_reg(2'd1, {{(CW-2){1'b0}}, ren, 1'b1});
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; rst_kind = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 0);
    repeat (20) @(negedge clk);
    check("R1 counting off after reset", 0);

    // Sweep: reload value, kind code, reset enable.
    for (int L = 0; L <= 5; L++) begin
      for (int kd = 0; kd < 4; kd++) begin
        for (int re = 0; re < 2; re++) begin
          rst_kind = 2'(kd);
          arm(L, re[0]);
          for (int k = 1; k <= 3 * L + 5; k++) begin
            int exp;
            string tag;
            @(negedge clk);
            exp = (k >= L + 1) ? 4 : 0;
            if (k == 2 * L + 2 && re == 1) exp += (kd == 2) ? 1 : 2;
            if (k == 2 * L + 2)
              tag = (re == 0) ? "R4 no request when disabled" :
                    (kd == 2) ? "R6 system kind" :
                    (kd == 3) ? "R5 power-on kind" : "R7 default kind";
            else if (k > 2 * L + 2) tag = "R8 no repeat pulse";
            else if (k == L + 1) tag = "R2 first expiry time";
            else tag = "R3 first expiry quiet";
            check(tag, exp);
          end
        end
      end
    end

    // Service between expiries (R9).
    rst_kind = 2'd3;
    arm(3, 1'b1);
    repeat (5) @(negedge clk);
    check("R2 flag set before service", 4);
    wr_reg(2'd2, '0);
    check("R9 flag cleared by service", 0);
    for (int m = 1; m <= 8; m++) begin
      @(negedge clk);
      check("R9 restart after service", (m >= 4 ? 4 : 0) + (m == 8 ? 2 : 0));
    end

    // Counting paused (R10).
    rst_kind = 2'd2;
    arm(4, 1'b1);
    repeat (2) @(negedge clk);
    wr_reg(2'd1, 16'd2);
    for (int m = 0; m < 20; m++) begin
      @(negedge clk);
      if (m % 5 == 4) check("R10 hold while disabled", 0);
    end
    wr_reg(2'd1, 16'd3);
    @(negedge clk);
    check("R10 count resumed from held value", 0);
    @(negedge clk);
    check("R10 expiry after resume", 4);

    // Reload write mid-period (R11).
    rst_kind = 2'd1;
    arm(5, 1'b1);
    repeat (2) @(negedge clk);
    wr_reg(2'd0, 16'd1);
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      check("R11 reload deferred", (j >= 3 ? 4 : 0) + (j == 5 ? 2 : 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule